// File: doc/BRIEF.md
# Autocorrelation Plateau Timing Detector

This block gives a coarse symbol-timing estimate for an OFDM receiver. The short training field makes a lag-16 autocorrelation metric stay high for as long as the repeated symbols last. The block measures how long that high region lasts. A packet-detect strobe arms it. From then on it counts every valid sample whose metric magnitude is above half of the signal-power estimate. The first valid sample that fails this test ends the plateau. The block then freezes the count, pulses a done flag and holds the result for a programmable number of valid samples. After that it returns to idle.

The half-power test is done without a divider, by comparing twice the metric with the power. On a clean channel the plateau ends close to sample 144. Results between 136 and 176 are the normal range for downstream logic. A plateau that never ends stops at a saturating limit, and the block reports it with an error flag. The autocorrelator, gain control and fine timing are not part of this block.

Top module: `plateau_timing_det`

## Requirements
- R1: After reset, `timing_count` is 0 and `timing_done`, `timing_hold` and `timing_err` are all low.
- R2: When `pkt_det` is high in the idle state, counting starts from 0. Each later valid sample with 2*`metric` > `power` adds one to `timing_count`, which is visible one clock after that sample.
- R3: A cycle with `samp_vld` low leaves `timing_count` and all state unchanged.
- R4: The threshold test is strict. A valid sample with 2*`metric` equal to `power` ends the plateau, just as a lower metric does.
- R5: When the plateau ends, `timing_done` is high for exactly one clock. `timing_hold` rises in that same clock, and `timing_count` keeps the number of above-threshold samples.
- R6: `timing_hold` stays high for exactly `HOLD_SAMPLES` valid samples. After that, the block is idle again with `timing_count` back at 0.
- R7: A `pkt_det` strobe during the hold period is ignored. The held count and the hold length do not change.
- R8: When the count reaches `CNT_LIMIT` while the metric is still above threshold, the count stops at `CNT_LIMIT`. `timing_err` is set, `timing_done` pulses and the hold begins. `timing_err` stays high until the hold ends.
- R9: In the idle state without `pkt_det`, above-threshold samples do not start a count and do not raise `timing_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| samp_vld | input | 1 | High on cycles that carry a new sample |
| pkt_det | input | 1 | Packet-detect strobe that arms the counter |
| metric | input | METRIC_W | Magnitude of the lag-16 autocorrelation |
| power | input | POWER_W | Signal-power estimate |
| timing_count | output | CNT_W | Live count while counting; frozen result while holding |
| timing_done | output | 1 | One-clock completion pulse |
| timing_hold | output | 1 | High while the result is held |
| timing_err | output | 1 | Plateau reached the saturating limit |

## Verification
The bench builds the detector with `CNT_LIMIT` = 200 and `HOLD_SAMPLES` = 6. With these values the saturation path is reached in a few hundred cycles, while ideal plateaus of 144 and 176 samples still fit below the limit. The short hold makes it practical to count the hold period sample by sample, with gaps in `samp_vld` and a stray `pkt_det` placed inside it. Metric and power pairs are chosen to sit exactly on the half-power boundary as well as just above it.

// File: rtl/plateau_timing_pkg.sv
package plateau_timing_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } plat_state_e;
endpackage

// File: rtl/plateau_half_cmp.sv
module plateau_half_cmp #(
  parameter int METRIC_W = 16,
  parameter int POWER_W  = 18
) (
  input  logic [METRIC_W-1:0] metric,
  input  logic [POWER_W-1:0]  power,
  output logic                above
);
  localparam int CMP_W = ((METRIC_W + 1) > POWER_W ? (METRIC_W + 1) : POWER_W) + 1;

  logic [CMP_W-1:0] twice_m;
  logic [CMP_W-1:0] pwr_ext;

  always_comb begin
    twice_m = CMP_W'(metric) << 1;
    pwr_ext = CMP_W'(power);
    above   = twice_m > pwr_ext;
  end
endmodule

// File: rtl/plateau_len_ctr.sv
module plateau_len_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || inc) cnt <= cnt_d;
  end
endmodule

// File: rtl/plateau_ctl_fsm.sv
module plateau_ctl_fsm
  import plateau_timing_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int CNT_LIMIT    = 255,
  parameter int HOLD_SAMPLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_vld,
  input  logic             pkt_det,
  input  logic             above,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             done,
  output logic             hold,
  output logic             err
);
  localparam int HC_W = $clog2(HOLD_SAMPLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CNT_LIMIT - 1);
  localparam logic [HC_W-1:0]  LAST_HOLD = HC_W'(HOLD_SAMPLES - 1);

  plat_state_e     state, state_d;
  logic [HC_W-1:0] hcnt, hcnt_d;
  logic            done_d, err_d;
  logic            hcnt_en;

  always_comb begin
    state_d = state;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    done_d  = 1'b0;
    err_d   = err;
    hcnt_d  = hcnt;
    unique case (state)
      ST_IDLE: begin
        if (pkt_det) begin
          state_d = ST_COUNT;
          cnt_clr = 1'b1;
          err_d   = 1'b0;
        end
      end
      ST_COUNT: begin
        if (samp_vld) begin
          if (above) begin
            cnt_inc = 1'b1;
            if (cnt == LAST_CNT) begin
              state_d = ST_HOLD;
              done_d  = 1'b1;
              err_d   = 1'b1;
              hcnt_d  = '0;
            end
          end else begin
            state_d = ST_HOLD;
            done_d  = 1'b1;
            hcnt_d  = '0;
          end
        end
      end
      ST_HOLD: begin
        if (samp_vld) begin
          if (hcnt == LAST_HOLD) begin
            state_d = ST_IDLE;
            cnt_clr = 1'b1;
            err_d   = 1'b0;
          end else begin
            hcnt_d = hcnt + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign hcnt_en = (state == ST_COUNT) || (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= state_d;
      done  <= done_d;
      err   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hcnt <= '0;
    else if (hcnt_en) hcnt <= hcnt_d;
  end

  assign hold = (state == ST_HOLD);
endmodule

// File: rtl/plateau_timing_det.sv
module plateau_timing_det #(
  parameter int METRIC_W     = 16,
  parameter int POWER_W      = 18,
  parameter int CNT_W        = 8,
  parameter int CNT_LIMIT    = 255,
  parameter int HOLD_SAMPLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp_vld,
  input  logic                pkt_det,
  input  logic [METRIC_W-1:0] metric,
  input  logic [POWER_W-1:0]  power,
  output logic [CNT_W-1:0]    timing_count,
  output logic                timing_done,
  output logic                timing_hold,
  output logic                timing_err
);
  logic above;
  logic cnt_clr;
  logic cnt_inc;

  plateau_half_cmp #(
    .METRIC_W(METRIC_W),
    .POWER_W (POWER_W)
  ) u_cmp (
    .metric(metric),
    .power (power),
    .above (above)
  );

  plateau_len_ctr #(
    .CNT_W(CNT_W)
  ) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .cnt  (timing_count)
  );

  plateau_ctl_fsm #(
    .CNT_W       (CNT_W),
    .CNT_LIMIT   (CNT_LIMIT),
    .HOLD_SAMPLES(HOLD_SAMPLES)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .samp_vld(samp_vld),
    .pkt_det (pkt_det),
    .above   (above),
    .cnt     (timing_count),
    .cnt_clr (cnt_clr),
    .cnt_inc (cnt_inc),
    .done    (timing_done),
    .hold    (timing_hold),
    .err     (timing_err)
  );
endmodule

// File: rtl/plateau_timing_chk.sv
module plateau_timing_chk #(
  parameter int CNT_W     = 8,
  parameter int CNT_LIMIT = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             samp_vld,
  input logic [CNT_W-1:0] timing_count,
  input logic             timing_done,
  input logic             timing_hold,
  input logic             timing_err
);
  // R5: completion is a single-clock pulse
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timing_done |=> !timing_done);

  // R5: completion coincides with the hold period
  assert_done_in_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timing_done |-> timing_hold);

  // R5: the held count does not move
  assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_hold && $past(timing_hold)) |-> (timing_count == $past(timing_count)));

  // R3: no valid sample, no count change
  assert_no_vld_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_vld |=> $stable(timing_count));

  // R8: the count never passes the limit
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timing_count <= CNT_W'(CNT_LIMIT));

  // R8: an error is only reported with a saturated count during hold
  assert_err_saturated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |-> (timing_hold && timing_count == CNT_W'(CNT_LIMIT)));
endmodule

bind plateau_timing_det plateau_timing_chk #(
  .CNT_W    (CNT_W),
  .CNT_LIMIT(CNT_LIMIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .samp_vld    (samp_vld),
  .timing_count(timing_count),
  .timing_done (timing_done),
  .timing_hold (timing_hold),
  .timing_err  (timing_err)
);

// File: tb/plateau_timing_det_test.sv
module plateau_timing_det_test;
  localparam int MW    = 16;
  localparam int PW    = 18;
  localparam int CW    = 8;
  localparam int LIMIT = 200;
  localparam int HOLDN = 6;

  logic          clk;
  logic          rst_n;
  logic          samp_vld;
  logic          pkt_det;
  logic [MW-1:0] metric;
  logic [PW-1:0] power;
  logic [CW-1:0] timing_count;
  logic          timing_done;
  logic          timing_hold;
  logic          timing_err;

  int n_checks = 0;
  int n_fail   = 0;

  plateau_timing_det #(
    .METRIC_W(MW), .POWER_W(PW), .CNT_W(CW),
    .CNT_LIMIT(LIMIT), .HOLD_SAMPLES(HOLDN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .pkt_det(pkt_det),
    .metric(metric), .power(power), .timing_count(timing_count),
    .timing_done(timing_done), .timing_hold(timing_hold), .timing_err(timing_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // apply inputs at a falling edge, return one full clock later
  task automatic drive(input logic v, input logic d, input int m, input int p);
    samp_vld = v;
    pkt_det  = d;
    metric   = MW'(m);
    power    = PW'(p);
    @(negedge clk);
  endtask

  task automatic above_n(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 600, 1000);
  endtask

  task automatic wait_hold_out(input string req);
    for (int i = 0; i < HOLDN - 1; i++) drive(1'b1, 1'b0, 0, 1000);
    check(req, timing_hold, 1);
    drive(1'b1, 1'b0, 0, 1000);
    check(req, timing_hold, 0);
    check(req, timing_count, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    samp_vld = 1'b0; pkt_det = 1'b0; metric = '0; power = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", timing_count, 0);
    check("R1 done", timing_done, 0);
    check("R1 hold", timing_hold, 0);
    check("R1 err", timing_err, 0);
  endtask

  task automatic t_idle_no_start();
    above_n(10);
    check("R9 count", timing_count, 0);
    check("R9 done", timing_done, 0);
    check("R9 hold", timing_hold, 0);
  endtask

  task automatic t_plateau(input int len, input bit gaps);
    drive(1'b1, 1'b1, 600, 1000);
    check("R2 start", timing_count, 0);
    for (int i = 0; i < len; i++) begin
      drive(1'b1, 1'b0, 600, 1000);
      if (gaps && (i % 16 == 3)) begin
        drive(1'b0, 1'b0, 0, 1000);
        check("R3 gap", timing_count, i + 1);
        check("R3 gap hold", timing_hold, 0);
      end
    end
    check("R2 count", timing_count, len);
    drive(1'b1, 1'b0, 100, 1000);
    check("R5 done", timing_done, 1);
    check("R5 hold", timing_hold, 1);
    check("R5 count", timing_count, len);
    check("R5 err", timing_err, 0);
    drive(1'b0, 1'b0, 600, 1000);
    check("R5 pulse end", timing_done, 0);
    check("R5 frozen", timing_count, len);
    // the gap above did not consume a hold sample
    wait_hold_out("R6");
  endtask

  task automatic t_boundary();
    drive(1'b1, 1'b1, 0, 0);
    drive(1'b1, 1'b0, 501, 1001);
    drive(1'b1, 1'b0, 501, 1001);
    check("R4 just above", timing_count, 2);
    drive(1'b1, 1'b0, 500, 1000);
    check("R4 equal ends", timing_done, 1);
    check("R4 count", timing_count, 2);
    wait_hold_out("R4 exit");
  endtask

  task automatic t_hold_ignore();
    drive(1'b1, 1'b1, 0, 0);
    above_n(7);
    drive(1'b1, 1'b0, 0, 1000);
    check("R7 done", timing_done, 1);
    drive(1'b1, 1'b1, 600, 1000);
    check("R7 count", timing_count, 7);
    check("R7 no redone", timing_done, 0);
    for (int i = 0; i < HOLDN - 2; i++) drive(1'b1, 1'b0, 600, 1000);
    check("R7 hold", timing_hold, 1);
    drive(1'b1, 1'b0, 600, 1000);
    check("R7 hold end", timing_hold, 0);
    check("R7 idle count", timing_count, 0);
  endtask

  task automatic t_timeout();
    drive(1'b1, 1'b1, 0, 0);
    above_n(LIMIT - 1);
    check("R8 before", timing_count, LIMIT - 1);
    check("R8 no err yet", timing_err, 0);
    drive(1'b1, 1'b0, 600, 1000);
    check("R8 count", timing_count, LIMIT);
    check("R8 err", timing_err, 1);
    check("R8 done", timing_done, 1);
    drive(1'b1, 1'b0, 600, 1000);
    check("R8 saturated", timing_count, LIMIT);
    check("R8 err held", timing_err, 1);
    for (int i = 0; i < HOLDN - 1; i++) drive(1'b1, 1'b0, 600, 1000);
    check("R8 err clear", timing_err, 0);
    check("R8 idle", timing_hold, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_no_start();
    t_plateau(144, 1'b1);
    t_plateau(176, 1'b0);
    t_boundary();
    t_hold_ignore();
    t_timeout();
    t_plateau(3, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule